// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block turns one burst request into the column address of every beat of a double-data-rate burst. A request carries a starting column, a length code, an ordering type and, for page-length bursts, the page size. The block then gives out two column addresses on each clock: one for the beat on the rising edge and one for the beat on the falling edge. It goes on until the burst is complete.

Fixed bursts of 2, 4 or 8 beats can be ordered in two ways. Sequential ordering counts upward and wraps inside the aligned block. Interleaved ordering XORs the start with the beat number. A page-length burst counts upward and wraps inside its page. It runs until a terminate strobe arrives. An illegal page-length request does not start a burst. Instead it raises a one-cycle error.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and on the first clock after it, `vld`, `last` and `err` are all low.
- R2: Sequential ordering (`ilv`=0) with length code 0, 1 or 2 (2, 4 or 8 beats) counts the low log2(length) column bits upward from the start and wraps inside the aligned block. For example, start 5 at 8 beats gives 5,6,7,0,1,2,3,4.
- R3: Interleaved ordering (`ilv`=1) gives beat n the low bits of start XOR n. For example, start 5 at 8 beats gives 5,4,7,6,1,0,3,2. The two columns of any valid interleaved pair differ only in bit 0.
- R4: In a fixed-length burst, the column bits above the low log2(length) bits equal those of the start column on every beat.
- R5: A start accepted at clock edge k puts beats 0 and 1 on `col_rise`/`col_fall` with `vld` high in the cycle after edge k. Each later cycle carries the next two beats with no gap, so 8 beats take four cycles.
- R6: `last` is high, together with `vld`, only in the cycle that carries the final pair of a fixed-length burst. `vld` is low in the cycle after that unless a new start was taken.
- R7: Length code 3 is a page-length sequential burst over a page of 2^`pg_lg` columns. It counts upward modulo the page size, keeping the column bits above the page fixed. It continues until a cycle in which `term` is high; that cycle shows `last` and is the final pair.
- R8: Length code 3 is illegal when `ilv`=1, when the start column is odd, or when `pg_lg` lies outside 2..COL_W. An illegal request sets `err` high for exactly the one cycle after the start and produces no beats.
- R9: A `start` is taken only when no burst is running, or in the cycle where `last` is high. A start while a burst runs before its last cycle has no effect on the burst. A start in the last cycle begins the next burst in the following cycle with no gap.
- R10: `term` has no effect on fixed-length bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request strobe |
| start_col | input | COL_W | Starting column of the request |
| bl_code | input | 2 | 0: 2 beats, 1: 4 beats, 2: 8 beats, 3: page length |
| ilv | input | 1 | 0: sequential, 1: interleaved |
| pg_lg | input | PGW | log2 of the page size, used for page-length bursts |
| term | input | 1 | Ends a page-length burst in the current cycle |
| vld | output | 1 | A pair of beat columns is valid |
| col_rise | output | COL_W | Column of the rising-edge beat |
| col_fall | output | COL_W | Column of the falling-edge beat |
| last | output | 1 | This pair is the last of the burst |
| err | output | 1 | Illegal page-length request rejected |

## Verification
The bench targets odd starts in both orderings, where an adder that carried out of the block, or a sequential rule applied to an interleaved burst, would change the upper column bits or produce the wrong order. Page-length bursts are run across the page boundary, where a design that wrapped on the wrong bit would leave its page. They are also run with late termination, where a design that stopped on its own would drop `vld`. Each of the three illegal page-length requests is sent, and a design that let any of them through would show beats. Starts are also sent mid-burst and exactly in the last cycle, where a design would either restart the burst or insert an idle gap.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10,
  localparam int PGW = $clog2(COL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  input  logic             ilv,
  input  logic [PGW-1:0]   pg_lg,
  input  logic             term,
  output logic             vld,
  output logic [COL_W-1:0] col_rise,
  output logic [COL_W-1:0] col_fall,
  output logic             last,
  output logic             err
);

  logic             busy, full_q, ilv_q, err_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q, mask_n;
  logic             bad, take;

  always_comb begin
    case (bl_code)
      2'd0: mask_n = COL_W'(1);
      2'd1: mask_n = COL_W'(3);
      2'd2: mask_n = COL_W'(7);
      default:
        for (int i = 0; i < COL_W; i++) mask_n[i] = (PGW'(i) < pg_lg);
    endcase
  end

  assign bad  = (bl_code == 2'd3) &&
                (ilv || start_col[0] || pg_lg < PGW'(2) || pg_lg > PGW'(COL_W));
  assign last = busy && (full_q ? term : ((idx_q + COL_W'(1)) == mask_q));
  assign take = start && (!busy || last);

  function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] n);
    if (ilv_q) return base_q ^ n;
    return (base_q & ~mask_q) | ((base_q + n) & mask_q);
  endfunction

  assign vld      = busy;
  assign err      = err_q;
  assign col_rise = col_at(idx_q);
  assign col_fall = col_at(idx_q + COL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      err_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
    end else begin
      err_q <= take && bad;
      if (take) begin
        busy   <= !bad;
        base_q <= start_col;
        idx_q  <= '0;
        mask_q <= mask_n;
        full_q <= (bl_code == 2'd3);
        ilv_q  <= ilv;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        idx_q <= idx_q + COL_W'(2);
      end
    end
  end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       bl_code,
  input logic             ilv,
  input logic             vld,
  input logic [COL_W-1:0] col_rise,
  input logic [COL_W-1:0] col_fall,
  input logic             last,
  input logic             err
);

  logic c_ilv, c_full;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ilv  <= 1'b0;
      c_full <= 1'b0;
    end else if (start && (!vld || last)) begin
      c_ilv  <= ilv;
      c_full <= (bl_code == 2'd3);
    end
  end

  // R6
  last_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> vld);

  // R8
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !vld);

  // R8
  err_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start));

  // R5
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !last) |=> vld);

  // R3
  ilv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && c_ilv) |-> ((col_rise ^ col_fall) == COL_W'(1)));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !last && !c_full) |=> (col_rise[COL_W-1:3] == $past(col_rise[COL_W-1:3])));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int PW = $clog2(CW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ilv = 1'b0, term = 1'b0;
  logic [CW-1:0] start_col = '0;
  logic [1:0] bl_code = '0;
  logic [PW-1:0] pg_lg = '0;
  logic vld, last, err;
  logic [CW-1:0] col_rise, col_fall;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(CW)) i_burst_col_seq (.*);

  int checks = 0, fails = 0, cycles = 0;

  // behavioural reference
  bit m_busy = 0, m_err = 0, m_ilv = 0, m_full = 0;
  int m_base = 0, m_n = 0, m_len = 0, m_size = 0;

  function automatic int ref_col(int n);
    if (m_ilv) return m_base ^ n;
    return (m_base - (m_base % m_size)) + ((m_base + n) % m_size);
  endfunction

  task automatic cyc(input bit st, input int c, input int b, input bit iv,
                     input int p, input bit tm, input string tag);
    bit e_last, acc, illegal;
    @(negedge clk);
    start = st; start_col = CW'(c); bl_code = 2'(b); ilv = iv;
    pg_lg = PW'(p); term = tm;
    #1;
    e_last = m_busy && (m_full ? tm : (m_n + 2 == m_len));
    checks++;
    if (vld !== m_busy || last !== e_last || err !== m_err ||
        (m_busy && (col_rise !== CW'(ref_col(m_n)) ||
                    col_fall !== CW'(ref_col(m_n + 1))))) begin
      fails++;
      $display("FAIL %s: got vld=%b last=%b err=%b cols=%0d,%0d exp vld=%b last=%b err=%b cols=%0d,%0d",
               tag, vld, last, err, col_rise, col_fall, m_busy, e_last, m_err,
               m_busy ? ref_col(m_n) : 0, m_busy ? ref_col(m_n + 1) : 0);
    end
    acc = st && (!m_busy || e_last);
    illegal = (b == 3) && (iv || (c % 2 == 1) || p < 2 || p > CW);
    m_err = acc && illegal;
    if (acc) begin
      m_busy = !illegal; m_base = c; m_n = 0; m_ilv = iv; m_full = (b == 3);
      m_len = (b == 3) ? 0 : (2 << b);
      m_size = (b == 3) ? (1 << p) : m_len;
    end else if (e_last) m_busy = 0;
    else if (m_busy) m_n += 2;
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk); checks++;
      if (vld !== 1'b0 || last !== 1'b0 || err !== 1'b0) begin
        fails++;
        $display("FAIL R1: got vld=%b last=%b err=%b exp 0 0 0", vld, last, err);
      end
    end
    rst_n = 1'b1;
    idle(2, "R1");
    // R2 sequential 2/4/8 beats, R5 timing, R6 last
    cyc(1, 1, 0, 0, 0, 0, "R2"); idle(2, "R6");
    cyc(1, 13, 1, 0, 0, 0, "R2"); idle(3, "R5");
    cyc(1, 'h2d5, 2, 0, 0, 0, "R4"); idle(5, "R4");
    // R3 interleave
    cyc(1, 14, 1, 1, 0, 0, "R3"); idle(3, "R3");
    cyc(1, 'h2d5, 2, 1, 0, 0, "R3"); idle(5, "R3");
    cyc(1, 3, 0, 1, 0, 0, "R3"); idle(2, "R3");
    // R7 page-length across page boundary, late term
    cyc(1, 30, 3, 0, 4, 0, "R7");
    idle(11, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7"); idle(2, "R7");
    cyc(1, 'h3fc, 3, 0, CW, 0, "R7"); idle(3, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7"); idle(2, "R7");
    // R8 illegal page-length requests
    cyc(1, 8, 3, 1, 4, 0, "R8"); idle(2, "R8");
    cyc(1, 9, 3, 0, 4, 0, "R8"); idle(2, "R8");
    cyc(1, 8, 3, 0, 1, 0, "R8"); idle(2, "R8");
    cyc(1, 8, 3, 0, CW + 1, 0, "R8"); idle(2, "R8");
    // R9 start mid-burst ignored, start in last cycle accepted
    cyc(1, 2, 2, 0, 0, 0, "R9");
    cyc(1, 100, 1, 1, 0, 0, "R9");
    cyc(1, 101, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    cyc(1, 'h155, 1, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    cyc(1, 8, 3, 1, 4, 0, "R9");
    idle(3, "R9");
    // R10 term ignored for fixed bursts
    cyc(1, 6, 2, 0, 0, 1, "R10");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, "R10");
    idle(2, "R10");
    finish_run();
  end
endmodule